// File: doc/BRIEF.md
# Index-port watchdog timer

This block is a countdown watchdog whose settings sit behind a two-byte I/O window: one byte-wide address takes a register index, the next one carries the data for that index. Configuration is shut by default. Software opens it by writing a key byte twice to the index port. It then writes a page number through the page-switch index to reach the watchdog registers. A closing byte written to the index port shuts the window again. The countdown itself keeps running whether the window is open or shut.

The timer counts down an 8-bit value on either a seconds strobe or a minutes strobe. Both strobes come from outside the block. When an enabled count reaches zero, the block raises `timeout`. Keyboard and mouse interrupt lines can each be allowed to reload the count from the last value that software programmed. This lets user activity stand in for a software keep-alive.

Top module: `idx_watchdog`

## Requirements
- R1: After reset the window is closed, every register holds zero, `timeout` is low and a read of the data port (0x2F) returns 0xFF.
- R2: Writing 0x87 to the index port (0x2E) twice in a row opens the window. Index 0x07 is then the page register. Writing 0x08 to it exposes the watchdog registers, which read back through the data port.
- R3: Any index-port byte other than 0x87 written after the first 0x87 discards the partial sequence, and the window stays closed.
- R4: While the window is closed, or is open with a page other than 0x08, data-port writes to the watchdog registers change nothing and data-port reads return 0xFF. The page register at index 0x07 reads back whenever the window is open.
- R5: Writing 0xAA to the index port of an open window closes it. The watchdog keeps its settings and keeps counting.
- R6: Index 0x30 bit 0 is the enable. The other bits of that register read as 0.
- R7: Index 0xF5 bit 3 selects the count unit: 0 counts `secTick` pulses and 1 counts `minTick` pulses. Pulses of the unselected strobe are ignored. The other bits read as 0.
- R8: Writing index 0xF6 loads both the count and the reload value. Reading it returns the live count. Each pulse of the selected strobe lowers the count by one while the watchdog is enabled, and the count holds while it is disabled.
- R9: `timeout` rises at the same clock edge at which an enabled count becomes zero. It stays high until a nonzero value is written to 0xF6 or the watchdog is disabled. The count never wraps below zero.
- R10: Index 0xF7 bit 6 lets `kbdIrq` reload the count from the last value written to 0xF6, and bit 7 does the same for `mouseIrq`. This reload acts only while the watchdog is enabled. A line whose bit is clear has no effect. The other bits read as 0.
- R11: After a timeout, interrupt pulses do not reload the count, so `timeout` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe for the byte on busWrData |
| busAddr | input | 8 | I/O address (index port or data port) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| secTick | input | 1 | One-cycle seconds strobe |
| minTick | input | 1 | One-cycle minutes strobe |
| kbdIrq | input | 1 | Keyboard interrupt line |
| mouseIrq | input | 1 | Mouse interrupt line |
| timeout | output | 1 | High while the enabled count is at zero |

## Verification
The access path is tried with a clean key sequence, a key sequence broken by a stray index byte, a data write under the wrong page, and writes made after the closing byte. Together these separate a lock machine that opens too easily from one that never re-closes. The countdown is driven with seconds and minutes strobes under both unit settings. This shows whether the unit bit really selects the strobe. Interrupt pulses are applied with each enable bit set and clear, before a timeout and after one, so that a reload from the wrong source, from a stale value, or after expiry changes the count that is read back.

// File: rtl/idxwd_pkg.sv
package idxwd_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Write strobes from the access control to the timer datapath
  typedef struct packed {
    logic  wrEnable;
    logic  wrUnit;
    logic  wrCount;
    logic  wrReset;
    byte_t data;
  } cfg_strobe_t;

  // Datapath state presented for read-back
  typedef struct packed {
    logic  enable;
    logic  minutes;
    logic  kbdOk;
    logic  mouseOk;
    byte_t count;
  } wd_status_t;

  typedef enum logic [1:0] {LK_CLOSED, LK_HALF, LK_OPEN} lock_state_t;
endpackage

// File: rtl/idxwd_ctrl.sv
module idxwd_ctrl import idxwd_pkg::*; #(
  parameter byte_t IDX_ADDR   = 8'h2E,
  parameter byte_t DATA_ADDR  = 8'h2F,
  parameter byte_t OPEN_KEY   = 8'h87,
  parameter byte_t CLOSE_KEY  = 8'hAA,
  parameter byte_t PAGE_REG   = 8'h07,
  parameter byte_t WD_PAGE    = 8'h08,
  parameter byte_t EN_REG     = 8'h30,
  parameter byte_t UNIT_REG   = 8'hF5,
  parameter byte_t CNT_REG    = 8'hF6,
  parameter byte_t RST_REG    = 8'hF7,
  parameter int    EN_BIT     = 0,
  parameter int    UNIT_BIT   = 3,
  parameter int    KBD_BIT    = 6,
  parameter int    MOUSE_BIT  = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  byte_t       busAddr,
  input  byte_t       busWrData,
  input  wd_status_t  status,
  output cfg_strobe_t stb,
  output byte_t       busRdData
);
  lock_state_t state;
  byte_t       indexReg;
  byte_t       pageReg;
  logic        idxHit, dataHit, onPage;

  assign idxHit  = busWr && (busAddr == IDX_ADDR);
  assign dataHit = busWr && (busAddr == DATA_ADDR);
  assign onPage  = (state == LK_OPEN) && (pageReg == WD_PAGE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= LK_CLOSED;
      indexReg <= '0;
      pageReg  <= '0;
    end else begin
      if (idxHit) begin
        unique case (state)
          LK_CLOSED: if (busWrData == OPEN_KEY) state <= LK_HALF;
          LK_HALF:   state <= (busWrData == OPEN_KEY) ? LK_OPEN : LK_CLOSED;
          LK_OPEN: begin
            if (busWrData == CLOSE_KEY) state <= LK_CLOSED;
            else indexReg <= busWrData;
          end
          default: state <= LK_CLOSED;
        endcase
      end
      if (dataHit && state == LK_OPEN && indexReg == PAGE_REG)
        pageReg <= busWrData;
    end
  end

  always_comb begin
    stb          = '0;
    stb.data     = busWrData;
    stb.wrEnable = dataHit && onPage && (indexReg == EN_REG);
    stb.wrUnit   = dataHit && onPage && (indexReg == UNIT_REG);
    stb.wrCount  = dataHit && onPage && (indexReg == CNT_REG);
    stb.wrReset  = dataHit && onPage && (indexReg == RST_REG);
  end

  always_comb begin
    busRdData = '1;
    if (busAddr == DATA_ADDR && state == LK_OPEN) begin
      if (indexReg == PAGE_REG) begin
        busRdData = pageReg;
      end else if (onPage) begin
        if (indexReg == EN_REG) begin
          busRdData = '0;
          busRdData[EN_BIT] = status.enable;
        end else if (indexReg == UNIT_REG) begin
          busRdData = '0;
          busRdData[UNIT_BIT] = status.minutes;
        end else if (indexReg == CNT_REG) begin
          busRdData = status.count;
        end else if (indexReg == RST_REG) begin
          busRdData = '0;
          busRdData[KBD_BIT]   = status.kbdOk;
          busRdData[MOUSE_BIT] = status.mouseOk;
        end
      end
    end
  end

  // R3
  restart_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == LK_HALF && idxHit && busWrData != OPEN_KEY) |=> (state == LK_CLOSED));

  // R5
  relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == LK_OPEN && idxHit && busWrData == CLOSE_KEY) |=> (state == LK_CLOSED));

  // R4
  closed_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != LK_OPEN && busAddr == DATA_ADDR) |-> (busRdData == '1));

  // R4
  closed_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != LK_OPEN) |-> !(stb.wrEnable || stb.wrUnit || stb.wrCount || stb.wrReset));
endmodule

// File: rtl/idxwd_dp.sv
module idxwd_dp import idxwd_pkg::*; #(
  parameter int EN_BIT    = 0,
  parameter int UNIT_BIT  = 3,
  parameter int KBD_BIT   = 6,
  parameter int MOUSE_BIT = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfg_strobe_t stb,
  input  logic        secTick,
  input  logic        minTick,
  input  logic        kbdIrq,
  input  logic        mouseIrq,
  output wd_status_t  status,
  output logic        timeout
);
  logic  enReg, minReg, kbdOk, mouseOk, timedOut;
  byte_t cnt, loadVal, cntNext;
  logic  enNext, tick, irqReload;

  always_comb begin
    enNext    = stb.wrEnable ? stb.data[EN_BIT] : enReg;
    tick      = minReg ? minTick : secTick;
    irqReload = enReg && !timedOut && ((kbdIrq && kbdOk) || (mouseIrq && mouseOk));
    cntNext   = cnt;
    if (stb.wrCount)                       cntNext = stb.data;
    else if (irqReload)                    cntNext = loadVal;
    else if (enReg && tick && cnt != '0)   cntNext = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      minReg   <= 1'b0;
      kbdOk    <= 1'b0;
      mouseOk  <= 1'b0;
      loadVal  <= '0;
      cnt      <= '0;
      timedOut <= 1'b0;
    end else begin
      enReg <= enNext;
      if (stb.wrUnit) minReg <= stb.data[UNIT_BIT];
      if (stb.wrReset) begin
        kbdOk   <= stb.data[KBD_BIT];
        mouseOk <= stb.data[MOUSE_BIT];
      end
      if (stb.wrCount) loadVal <= stb.data;
      cnt      <= cntNext;
      timedOut <= enNext && (cntNext == '0);
    end
  end

  assign timeout = timedOut;
  assign status  = '{enable: enReg, minutes: minReg, kbdOk: kbdOk,
                     mouseOk: mouseOk, count: cnt};

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enReg && !stb.wrCount) |=> $stable(cnt));

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && !stb.wrCount) |=> (cnt == '0));

  // R9
  timeout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timedOut && !stb.wrCount && !stb.wrEnable) |=> timedOut);

  // R10
  kbd_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enReg && !timedOut && kbdIrq && kbdOk && !stb.wrCount) |=> (cnt == $past(loadVal)));
endmodule

// File: rtl/idx_watchdog.sv
module idx_watchdog import idxwd_pkg::*; #(
  parameter byte_t IDX_ADDR  = 8'h2E,
  parameter byte_t DATA_ADDR = 8'h2F,
  parameter byte_t OPEN_KEY  = 8'h87,
  parameter byte_t CLOSE_KEY = 8'hAA,
  parameter byte_t PAGE_REG  = 8'h07,
  parameter byte_t WD_PAGE   = 8'h08,
  parameter byte_t EN_REG    = 8'h30,
  parameter byte_t UNIT_REG  = 8'hF5,
  parameter byte_t CNT_REG   = 8'hF6,
  parameter byte_t RST_REG   = 8'hF7,
  parameter int    EN_BIT    = 0,
  parameter int    UNIT_BIT  = 3,
  parameter int    KBD_BIT   = 6,
  parameter int    MOUSE_BIT = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [7:0]  busAddr,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  input  logic        secTick,
  input  logic        minTick,
  input  logic        kbdIrq,
  input  logic        mouseIrq,
  output logic        timeout
);
  cfg_strobe_t stb;
  wd_status_t  status;

  idxwd_ctrl #(
    .IDX_ADDR(IDX_ADDR), .DATA_ADDR(DATA_ADDR), .OPEN_KEY(OPEN_KEY),
    .CLOSE_KEY(CLOSE_KEY), .PAGE_REG(PAGE_REG), .WD_PAGE(WD_PAGE),
    .EN_REG(EN_REG), .UNIT_REG(UNIT_REG), .CNT_REG(CNT_REG), .RST_REG(RST_REG),
    .EN_BIT(EN_BIT), .UNIT_BIT(UNIT_BIT), .KBD_BIT(KBD_BIT), .MOUSE_BIT(MOUSE_BIT)
  ) ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .status(status), .stb(stb), .busRdData(busRdData)
  );

  idxwd_dp #(
    .EN_BIT(EN_BIT), .UNIT_BIT(UNIT_BIT), .KBD_BIT(KBD_BIT), .MOUSE_BIT(MOUSE_BIT)
  ) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .secTick(secTick), .minTick(minTick),
    .kbdIrq(kbdIrq), .mouseIrq(mouseIrq), .status(status), .timeout(timeout)
  );
endmodule

// File: tb/idx_watchdog_test.sv
`timescale 1ns/1ps
module idx_watchdog_test;
  logic       clk = 1'b0, rstN = 1'b0, busWr = 1'b0;
  logic [7:0] busAddr = 8'h00, busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       secTick = 1'b0, minTick = 1'b0, kbdIrq = 1'b0, mouseIrq = 1'b0;
  logic       timeout;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  idx_watchdog uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .secTick(secTick),
    .minTick(minTick), .kbdIrq(kbdIrq), .mouseIrq(mouseIrq), .timeout(timeout)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic portWr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWrData = v;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic idxWr(input logic [7:0] v);  portWr(8'h2E, v); endtask
  task automatic dataWr(input logic [7:0] v); portWr(8'h2F, v); endtask

  task automatic dataRd(output logic [7:0] v);
    busAddr = 8'h2F; #1; v = busRdData;
  endtask

  task automatic setReg(input logic [7:0] r, input logic [7:0] v);
    idxWr(r); dataWr(v);
  endtask

  task automatic getReg(input logic [7:0] r, output logic [7:0] v);
    idxWr(r); dataRd(v);
  endtask

  // which: 0 sec, 1 min, 2 kbd, 3 mouse
  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (which)
        0: secTick = 1'b1; 1: minTick = 1'b1;
        2: kbdIrq = 1'b1;  default: mouseIrq = 1'b1;
      endcase
      @(negedge clk);
      secTick = 1'b0; minTick = 1'b0; kbdIrq = 1'b0; mouseIrq = 1'b0;
    end
    #1;
  endtask

  task automatic testReset();
    logic [7:0] v;
    dataRd(v);
    check("R1 closed read after reset", v, 8'hFF);
    check("R1 timeout after reset", timeout, 0);
  endtask

  task automatic testBrokenSequence();
    logic [7:0] v;
    idxWr(8'h87); idxWr(8'h55); idxWr(8'h87);
    dataRd(v);
    check("R3 stray byte restarts unlock", v, 8'hFF);
    idxWr(8'h07);
    dataWr(8'h08);
    dataRd(v);
    check("R3 still closed after broken sequence", v, 8'hFF);
  endtask

  task automatic testUnlockAndPage();
    logic [7:0] v;
    idxWr(8'h87); idxWr(8'h87); idxWr(8'h07);
    dataRd(v);
    check("R4 page register readable when open", v, 8'h00);
    dataWr(8'h05);
    setReg(8'h30, 8'h01);
    dataRd(v);
    check("R4 wrong page reads 0xFF", v, 8'hFF);
    setReg(8'h07, 8'h08);
    dataRd(v);
    check("R2 page register holds 0x08", v, 8'h08);
    getReg(8'h30, v);
    check("R4 write on wrong page ignored", v, 8'h00);
  endtask

  task automatic testFieldMasks();
    logic [7:0] v;
    setReg(8'hF6, 8'h05);
    setReg(8'h30, 8'hFF); dataRd(v);
    check("R6 enable reads only bit 0", v, 8'h01);
    check("R9 no timeout with nonzero count", timeout, 0);
    setReg(8'hF5, 8'hFF); dataRd(v);
    check("R7 unit reads only bit 3", v, 8'h08);
    setReg(8'hF5, 8'h00);
    setReg(8'hF7, 8'hFF); dataRd(v);
    check("R10 reset control reads bits 7:6", v, 8'hC0);
    setReg(8'hF7, 8'h00);
  endtask

  task automatic testCounting();
    logic [7:0] v;
    idxWr(8'hF6);
    pulse(0, 2); dataRd(v);
    check("R8 two seconds counted", v, 8'h03);
    pulse(1, 1); dataRd(v);
    check("R7 minute strobe ignored in seconds mode", v, 8'h03);
    setReg(8'hF5, 8'h08); idxWr(8'hF6);
    pulse(1, 1); dataRd(v);
    check("R7 minute strobe counted in minutes mode", v, 8'h02);
    pulse(0, 1); dataRd(v);
    check("R7 second strobe ignored in minutes mode", v, 8'h02);
    setReg(8'hF5, 8'h00);
    setReg(8'h30, 8'h00); idxWr(8'hF6);
    pulse(0, 1); dataRd(v);
    check("R8 count holds while disabled", v, 8'h02);
    setReg(8'h30, 8'h01);
  endtask

  task automatic testTimeout();
    logic [7:0] v;
    idxWr(8'hF6);
    pulse(0, 1);
    check("R9 timeout low at count 1", timeout, 0);
    pulse(0, 1); dataRd(v);
    check("R9 count reached zero", v, 8'h00);
    check("R9 timeout raised at zero", timeout, 1);
    pulse(0, 1); dataRd(v);
    check("R9 count does not wrap", v, 8'h00);
    setReg(8'hF7, 8'h40); idxWr(8'hF6);
    pulse(2, 1); dataRd(v);
    check("R11 interrupt ignored after timeout", v, 8'h00);
    check("R11 timeout stays high", timeout, 1);
    setReg(8'hF6, 8'h04);
    check("R9 rewrite clears timeout", timeout, 0);
    setReg(8'hF6, 8'h00);
    check("R9 writing zero while enabled times out", timeout, 1);
    setReg(8'h30, 8'h00);
    check("R9 disable clears timeout", timeout, 0);
    setReg(8'hF7, 8'h00);
    setReg(8'hF6, 8'h06);
    setReg(8'h30, 8'h01);
  endtask

  task automatic testInterruptReload();
    logic [7:0] v;
    idxWr(8'hF6);
    pulse(0, 1);
    pulse(2, 1); dataRd(v);
    check("R10 keyboard ignored when not allowed", v, 8'h05);
    setReg(8'hF7, 8'h40); idxWr(8'hF6);
    pulse(2, 1); dataRd(v);
    check("R10 keyboard reloads last written value", v, 8'h06);
    pulse(0, 2);
    pulse(3, 1); dataRd(v);
    check("R10 mouse ignored when not allowed", v, 8'h04);
    setReg(8'hF7, 8'h80); idxWr(8'hF6);
    pulse(3, 1); dataRd(v);
    check("R10 mouse reloads last written value", v, 8'h06);
  endtask

  task automatic testRelock();
    logic [7:0] v;
    idxWr(8'hAA);
    dataRd(v);
    check("R5 closing byte shuts window", v, 8'hFF);
    idxWr(8'h30); dataWr(8'h00);
    idxWr(8'hF6); dataWr(8'h40);
    pulse(0, 5);
    check("R5 counting continues while closed", timeout, 0);
    pulse(0, 1);
    check("R4 closed writes ignored, count expires", timeout, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBrokenSequence();
    testUnlockAndPage();
    testFieldMasks();
    testCounting();
    testTimeout();
    testInterruptReload();
    testRelock();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule